// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Logic

This block watches the slow status pins of two removable-card sockets: the pair of card-detect pins, two battery-voltage-detect pins, ready/busy and write-protect. It also watches a single-cycle card-access timeout pulse for each socket. Each raw pin is synchronised with two flops. Any edge of the synchronised level latches a sticky change bit in that socket's status word. Software reads the word through a readback bus and clears pending bits by writing a mask. A per-socket enable lets a pending change drive a shared status interrupt line, the higher-priority of the two interrupt lines the host has.

The block also turns card-detect activity into clean insertion and removal events. A card counts as present only when both detect pins are high, and as absent only when both are low. An occupied flag per socket allows only one insertion per present period and one removal per absent period. Each event is a one-cycle strobe that carries the socket number. When both sockets qualify in the same cycle, socket 0 is reported first and socket 1 in the following cycle.

Top module: `pcsc_status_top`

## Requirements
- R1: While reset is asserted and right after it, every change bit, enable and occupied flag is clear. The interrupt and both event strobes are low, and every readback word is 0 when all pins are low.
- R2: Status word bits 13..8 give the synchronised pin levels. Bit 8 is detect 1, bit 9 detect 2, bit 10 battery 1, bit 11 battery 2, bit 12 ready and bit 13 write-protect. They follow a pin change after the second rising edge. Bits 7..6 read 0.
- R3: Any edge of a synchronised level sets a sticky change bit one edge later, after the third edge from the pin change. Bit 0 is detect (either detect pin), bit 1 battery 1, bit 2 battery 2, bit 3 ready and bit 4 write-protect.
- R4: A timeout pulse sets change bit 5 of its socket at the next rising edge.
- R5: A write with `wr_sel`=0 clears the change bits of socket `wr_sock` wherever `wr_data[5:0]` is 1. All other bits are left as they are, so writing 0x3fff clears all of them.
- R6: A change that sets a bit in the same cycle as an acknowledge of that bit leaves the bit set.
- R7: A write with `wr_sel`=1 loads `wr_data[0]` as the enable of socket `wr_sock`. `irq_stat` is high exactly when some socket is enabled and has a change bit set.
- R8: When both detect levels are high and the socket is not occupied, `evt_ins` pulses for one cycle with `evt_sock` naming the socket, and the socket becomes occupied.
- R9: When both detect levels are low and the socket is occupied, `evt_rem` pulses for one cycle with `evt_sock` naming the socket, and the socket becomes free.
- R10: A mixed detect state (one pin high, one low), or a state that matches the occupied flag, produces no event and leaves occupancy unchanged.
- R11: If both sockets qualify in the same cycle, socket 0's event comes first and socket 1's comes in the next cycle. At most one occupied flag changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd1_raw | input | NSOCK | Raw detect pin 1, one bit per socket |
| cd2_raw | input | NSOCK | Raw detect pin 2, one bit per socket |
| bvd1_raw | input | NSOCK | Raw battery detect 1 |
| bvd2_raw | input | NSOCK | Raw battery detect 2 |
| rdy_raw | input | NSOCK | Raw ready/busy |
| wp_raw | input | NSOCK | Raw write-protect |
| tmo_pulse | input | NSOCK | Synchronous card-access timeout pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: acknowledge mask, 1: enable |
| wr_sock | input | SOCK_W | Target socket of the write |
| wr_data | input | 14 | Write data |
| stat_rd | output | NSOCK*14 | Status words, socket s at bits s*14 upward |
| irq_stat | output | 1 | Status-change interrupt |
| evt_ins | output | 1 | Insertion event strobe |
| evt_rem | output | 1 | Removal event strobe |
| evt_sock | output | SOCK_W | Socket of the current event |

## Verification
A wrong occupied flag shows up at the ports as a missing or duplicated `evt_ins`/`evt_rem` strobe. It appears within three edges of the next detect change on that socket. A bad change bit or mask appears in the readback word and in `irq_stat` on the cycle after the edge or write that should have set or cleared it. The bench keeps a cycle-exact reference of the synchroniser, the sticky bits and the occupancy. It compares the reference every cycle under random pin toggles and writes, including same-cycle acknowledge and change.

// File: rtl/pcsc_pkg.sv
package pcsc_pkg;
  localparam int PIN_N    = 6;   // detect1, detect2, batt1, batt2, ready, wprot
  localparam int CHG_N    = 6;   // detect, batt1, batt2, ready, wprot, timeout
  localparam int STAT_W   = 14;
  localparam int LIVE_LSB = 8;
  localparam int GAP_W    = LIVE_LSB - CHG_N;

  typedef enum logic { WSEL_ACK = 1'b0, WSEL_ENA = 1'b1 } wsel_e;

  // change vector from current and previous synchronised level
  function automatic logic [CHG_N-1:0] edge_bits(input logic [PIN_N-1:0] now,
                                                 input logic [PIN_N-1:0] old,
                                                 input logic tmo);
    logic [PIN_N-1:0] d;
    d = now ^ old;
    return {tmo, d[5], d[4], d[3], d[2], d[1] | d[0]};
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [PIN_N-1:0] live,
                                                    input logic [CHG_N-1:0] chg);
    return {live, {GAP_W{1'b0}}, chg};
  endfunction

  function automatic logic both_high(input logic [PIN_N-1:0] live);
    return live[0] & live[1];
  endfunction

  function automatic logic both_low(input logic [PIN_N-1:0] live);
    return ~live[0] & ~live[1];
  endfunction
endpackage

// File: rtl/pcsc_sync.sv
module pcsc_sync #(
  parameter int W     = 6,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);
  logic [W-1:0] stg [DEPTH+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i <= DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl   = stg[DEPTH-1];
  assign lvl_d = stg[DEPTH];
endmodule

// File: rtl/pcsc_sock.sv
module pcsc_sock
  import pcsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] lvl,
  input  logic [PIN_N-1:0] lvl_d,
  input  logic             tmo,
  input  logic             ack_we,
  input  logic [CHG_N-1:0] ack_mask,
  input  logic             en_we,
  input  logic             en_val,
  input  logic             grant,
  output logic [CHG_N-1:0] chg,
  output logic             en,
  output logic             occ,
  output logic             req_ins,
  output logic             req_rem
);
  logic [CHG_N-1:0] set_vec;
  logic [CHG_N-1:0] clr_vec;
  logic [CHG_N-1:0] chg_q;
  logic             en_q;
  logic             occ_q;

  assign set_vec = edge_bits(lvl, lvl_d, tmo);
  assign clr_vec = ack_we ? ack_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= '0;
      en_q  <= 1'b0;
      occ_q <= 1'b0;
    end else begin
      chg_q <= (chg_q & ~clr_vec) | set_vec;   // set wins over clear
      if (en_we) en_q <= en_val;
      if (grant) occ_q <= ~occ_q;
    end
  end

  assign req_ins = both_high(lvl) & ~occ_q;
  assign req_rem = both_low(lvl) & occ_q;
  assign chg     = chg_q;
  assign en      = en_q;
  assign occ     = occ_q;
endmodule

// File: rtl/pcsc_evt_arb.sv
module pcsc_evt_arb #(
  parameter  int NSOCK  = 2,
  localparam int SOCK_W = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSOCK-1:0]  req_ins,
  input  logic [NSOCK-1:0]  req_rem,
  output logic [NSOCK-1:0]  grant,
  output logic              evt_ins,
  output logic              evt_rem,
  output logic [SOCK_W-1:0] evt_sock
);
  logic              found;
  logic [SOCK_W-1:0] sel_idx;
  logic              ins_q, rem_q;
  logic [SOCK_W-1:0] sock_q;

  // lowest socket number wins
  always_comb begin
    grant   = '0;
    found   = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < NSOCK; i++) begin
      if (!found && (req_ins[i] || req_rem[i])) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        sel_idx  = SOCK_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= 1'b0;
      rem_q  <= 1'b0;
      sock_q <= '0;
    end else begin
      ins_q  <= |(grant & req_ins);
      rem_q  <= |(grant & req_rem);
      sock_q <= found ? sel_idx : '0;
    end
  end

  assign evt_ins  = ins_q;
  assign evt_rem  = rem_q;
  assign evt_sock = sock_q;
endmodule

// File: rtl/pcsc_status_top.sv
module pcsc_status_top
  import pcsc_pkg::*;
#(
  parameter  int NSOCK      = 2,
  parameter  int SYNC_DEPTH = 2,
  localparam int SOCK_W     = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSOCK-1:0]         cd1_raw,
  input  logic [NSOCK-1:0]         cd2_raw,
  input  logic [NSOCK-1:0]         bvd1_raw,
  input  logic [NSOCK-1:0]         bvd2_raw,
  input  logic [NSOCK-1:0]         rdy_raw,
  input  logic [NSOCK-1:0]         wp_raw,
  input  logic [NSOCK-1:0]         tmo_pulse,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [SOCK_W-1:0]        wr_sock,
  input  logic [STAT_W-1:0]        wr_data,
  output logic [NSOCK*STAT_W-1:0]  stat_rd,
  output logic                     irq_stat,
  output logic                     evt_ins,
  output logic                     evt_rem,
  output logic [SOCK_W-1:0]        evt_sock
);
  logic [NSOCK-1:0] req_ins_vec, req_rem_vec, grant_vec;
  logic [NSOCK-1:0] occ_vec, en_vec, pend_vec;
  logic             ack_hit, ena_hit;
  logic             unused_wr_hi;

  assign ack_hit      = wr_en && (wsel_e'(wr_sel) == WSEL_ACK);
  assign ena_hit      = wr_en && (wsel_e'(wr_sel) == WSEL_ENA);
  assign unused_wr_hi = ^wr_data[STAT_W-1:CHG_N];

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    logic [PIN_N-1:0] raw, lvl, lvl_d;
    logic [CHG_N-1:0] chg;
    logic             hit;

    assign raw = {wp_raw[s], rdy_raw[s], bvd2_raw[s], bvd1_raw[s], cd2_raw[s], cd1_raw[s]};
    assign hit = (wr_sock == SOCK_W'(s));

    pcsc_sync #(.W(PIN_N), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw), .lvl(lvl), .lvl_d(lvl_d)
    );

    pcsc_sock u_sock (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .lvl_d(lvl_d), .tmo(tmo_pulse[s]),
      .ack_we(ack_hit && hit), .ack_mask(wr_data[CHG_N-1:0]),
      .en_we(ena_hit && hit), .en_val(wr_data[0]), .grant(grant_vec[s]),
      .chg(chg), .en(en_vec[s]), .occ(occ_vec[s]),
      .req_ins(req_ins_vec[s]), .req_rem(req_rem_vec[s])
    );

    assign pend_vec[s]                  = |chg;
    assign stat_rd[s*STAT_W +: STAT_W]  = pack_status(lvl, chg);
  end

  pcsc_evt_arb #(.NSOCK(NSOCK)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_ins(req_ins_vec), .req_rem(req_rem_vec),
    .grant(grant_vec), .evt_ins(evt_ins), .evt_rem(evt_rem), .evt_sock(evt_sock)
  );

  assign irq_stat = |(en_vec & pend_vec);
endmodule

// File: rtl/pcsc_status_chk.sv
module pcsc_status_chk #(
  parameter  int NSOCK  = 2,
  localparam int SOCK_W = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSOCK-1:0]  occ,
  input logic [NSOCK-1:0]  en,
  input logic              irq_stat,
  input logic              evt_ins,
  input logic              evt_rem,
  input logic [SOCK_W-1:0] evt_sock
);
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(evt_ins && evt_rem)); // R8
  AST_INS_MARKS: assert property (@(posedge clk) disable iff (!rst_n) evt_ins |-> occ[evt_sock]); // R8
  AST_REM_FREES: assert property (@(posedge clk) disable iff (!rst_n) evt_rem |-> !occ[evt_sock]); // R9
  AST_OCC_ONLY_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n) !$stable(occ) |-> (evt_ins || evt_rem)); // R10
  AST_OCC_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) $countones(occ ^ $past(occ)) <= 1); // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) (en == '0) |-> !irq_stat); // R7
endmodule

bind pcsc_status_top pcsc_status_chk #(.NSOCK(NSOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ_vec), .en(en_vec), .irq_stat(irq_stat),
  .evt_ins(evt_ins), .evt_rem(evt_rem), .evt_sock(evt_sock)
);

// File: tb/pcsc_status_top_tb.sv
`timescale 1ns/1ps
module pcsc_status_top_tb;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] pin [NS];
  logic [NS-1:0] tmo;
  logic wr_en, wr_sel;
  logic [0:0] wr_sock;
  logic [13:0] wr_data;
  logic [NS*14-1:0] stat_rd;
  logic irq_stat, evt_ins, evt_rem;
  logic [0:0] evt_sock;
  logic [NS-1:0] cd1, cd2, bv1, bv2, rdy, wp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      cd1[s] = pin[s][0]; cd2[s] = pin[s][1]; bv1[s] = pin[s][2];
      bv2[s] = pin[s][3]; rdy[s] = pin[s][4]; wp[s]  = pin[s][5];
    end
  end

  pcsc_status_top u_dut (
    .clk(clk), .rst_n(rst_n), .cd1_raw(cd1), .cd2_raw(cd2), .bvd1_raw(bv1),
    .bvd2_raw(bv2), .rdy_raw(rdy), .wp_raw(wp), .tmo_pulse(tmo),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_sock(wr_sock), .wr_data(wr_data),
    .stat_rd(stat_rd), .irq_stat(irq_stat), .evt_ins(evt_ins),
    .evt_rem(evt_rem), .evt_sock(evt_sock)
  );

  // reference state
  logic [5:0] m_s1 [NS];
  logic [5:0] m_s2 [NS];
  logic [5:0] m_s3 [NS];
  logic [5:0] m_chg [NS];
  logic [NS-1:0] m_en, m_occ;
  logic m_ins, m_rem;
  logic [0:0] m_sock;

  function automatic logic [13:0] exp_stat(input int s);
    return {m_s2[s], 2'b00, m_chg[s]};
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int s = 0; s < NS; s++) r |= m_en[s] && (m_chg[s] != 6'd0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      m_s1[s] = '0; m_s2[s] = '0; m_s3[s] = '0; m_chg[s] = '0;
    end
    m_en = '0; m_occ = '0; m_ins = 0; m_rem = 0; m_sock = '0;
  endtask

  task automatic model_update();
    bit found = 0;
    m_ins = 0; m_rem = 0; m_sock = '0;
    for (int s = 0; s < NS; s++) begin
      bit ri = m_s2[s][0] && m_s2[s][1] && !m_occ[s];
      bit rr = !m_s2[s][0] && !m_s2[s][1] && m_occ[s];
      if (!found && (ri || rr)) begin
        found = 1; m_ins = ri; m_rem = rr; m_sock = 1'(s);
      end
    end
    if (found) m_occ[m_sock] = ~m_occ[m_sock];
    for (int s = 0; s < NS; s++) begin
      logic [5:0] d = m_s2[s] ^ m_s3[s];
      logic [5:0] st = {tmo[s], d[5], d[4], d[3], d[2], d[1] | d[0]};
      logic [5:0] ak = (wr_en && !wr_sel && wr_sock == 1'(s)) ? wr_data[5:0] : 6'd0;
      m_chg[s] = (m_chg[s] & ~ak) | st;
      if (wr_en && wr_sel && wr_sock == 1'(s)) m_en[s] = wr_data[0];
      m_s3[s] = m_s2[s]; m_s2[s] = m_s1[s]; m_s1[s] = pin[s];
    end
  endtask

  task automatic compare_all();
    for (int s = 0; s < NS; s++)
      chk(stat_rd[s*14 +: 14] == exp_stat(s), "R2 R3 R5 status word", stat_rd[s*14 +: 14], exp_stat(s));
    chk(irq_stat == exp_irq(), "R7 interrupt", irq_stat, exp_irq());
    chk(evt_ins == m_ins, "R8 insertion strobe", evt_ins, m_ins);
    chk(evt_rem == m_rem, "R9 removal strobe", evt_rem, m_rem);
    if (m_ins || m_rem) chk(evt_sock == m_sock, "R11 event socket", evt_sock, m_sock);
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic write(input bit sel, input int s, input logic [13:0] d);
    wr_en = 1; wr_sel = sel; wr_sock = 1'(s); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NS; s++) pin[s] = '0;
    tmo = '0; wr_en = 0; wr_sel = 0; wr_sock = '0; wr_data = '0;
    model_reset();
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stat_rd == '0, "R1 status at reset", stat_rd, 0);
    chk(irq_stat == 0 && evt_ins == 0 && evt_rem == 0, "R1 outputs at reset",
        {irq_stat, evt_ins, evt_rem}, 0);
    rst_n = 1;
    tick();

    // insertion on socket 0
    pin[0][1:0] = 2'b11;
    tick(); tick();
    chk(stat_rd[9:8] == 2'b11, "R2 live detect after two edges", stat_rd[9:8], 3);
    chk(stat_rd[0] == 0 && evt_ins == 0, "R3 change not yet latched", {stat_rd[0], evt_ins}, 0);
    tick();
    chk(stat_rd[0] == 1, "R3 detect change bit", stat_rd[0], 1);
    chk(evt_ins == 1 && evt_sock == 0, "R8 insertion socket 0", {evt_ins, evt_sock}, 2);
    chk(irq_stat == 0, "R7 masked when disabled", irq_stat, 0);
    tick();
    chk(evt_ins == 0, "R8 strobe lasts one cycle", evt_ins, 0);

    // enable then acknowledge everything
    write(1, 0, 14'h0001);
    chk(irq_stat == 1, "R7 enabled pending raises interrupt", irq_stat, 1);
    write(0, 0, 14'h3fff);
    chk(stat_rd[5:0] == 0 && irq_stat == 0, "R5 full acknowledge", {stat_rd[5:0], irq_stat}, 0);

    // partial removal: no event
    pin[0][0] = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(evt_rem == 0 && evt_ins == 0, "R10 mixed detect gives no event", {evt_ins, evt_rem}, 0);
    end
    pin[0][1] = 0;
    tick(); tick(); tick();
    chk(evt_rem == 1 && evt_sock == 0, "R9 removal socket 0", {evt_rem, evt_sock}, 2);
    tick();
    chk(evt_rem == 0, "R10 no second removal", evt_rem, 0);

    // simultaneous insertion
    pin[0][1:0] = 2'b11; pin[1][1:0] = 2'b11;
    tick(); tick(); tick();
    chk(evt_ins == 1 && evt_sock == 0, "R11 socket 0 first", {evt_ins, evt_sock}, 2);
    tick();
    chk(evt_ins == 1 && evt_sock == 1, "R11 socket 1 next cycle", {evt_ins, evt_sock}, 3);
    write(0, 0, 14'h3fff);
    write(0, 1, 14'h3fff);

    // acknowledge in the same cycle as a write-protect edge
    pin[1][5] = 1;
    tick(); tick();
    write(0, 1, 14'h3fff);
    chk(stat_rd[14+4] == 1, "R6 change beats acknowledge", stat_rd[14+4], 1);

    // timeout pulse and selective acknowledge
    tmo[1] = 1;
    tick();
    tmo[1] = 0;
    chk(stat_rd[14+5] == 1, "R4 timeout bit", stat_rd[14+5], 1);
    write(0, 1, 14'h0020);
    chk(stat_rd[14+5] == 0 && stat_rd[14+4] == 1, "R5 masked acknowledge",
        {stat_rd[14+5], stat_rd[14+4]}, 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int s = int'($urandom % NS);
      if ($urandom % 8 == 0) pin[s] ^= 6'(1 << ($urandom % 6));
      if ($urandom % 12 == 0) pin[s][1:0] = ($urandom % 2) ? 2'b11 : 2'b00;
      tmo = ($urandom % 32 == 0) ? NS'(1 << ($urandom % NS)) : '0;
      wr_en = ($urandom % 10 == 0);
      wr_sel = ($urandom % 3 == 0);
      wr_sock = 1'($urandom % NS);
      wr_data = ($urandom % 4 == 0) ? 14'h3fff : 14'($urandom);
      tick();
    end
    wr_en = 0; tmo = '0;
    tick();
    finish_run();
  end
endmodule